// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Aligned Updates

This block produces four independent pulse-width-modulated outputs. A 32-bit register bus sets them up, with a combinational read path and a read strobe. Each channel has a mode word, an active duty value and an active period value. The mode word holds a power-of-two clock prescaler and an output polarity bit. Each channel also has two shadow registers, one for duty and one for period. A value written to a shadow register waits and is copied into the active register only when the current period ends. Software can therefore change a running waveform without producing a torn or runt pulse.

A channel starts when a 1 is written to its bit of the start register. It stops when a 1 is written to its bit of the stop register. A stop request waits for the end of the current period. A status word shows which channels are running. A flag word records every period end, one bit per channel, and a read of the flag word clears it. Software uses these flags to learn when staged values have been applied.

Top module: `pwmc_top`

## Requirements
- R1: After reset every output is low, and the status word, the flag word and all channel registers read as zero.
- R2: Register map (byte addresses): start 0x004, stop 0x008, status 0x00C, flags 0x01C. Channel c has its bank at 0x200 + c*0x20, with mode at +0x00, duty at +0x04, staged duty at +0x08, period at +0x0C and staged period at +0x10. Duty and period registers keep only bits [15:0], and their upper bits read as zero. The mode word reads back bits [3:0] (prescaler) and bit 9 (polarity), and all its other bits read as zero.
- R3: A running channel counts prescaled ticks from 0 to period-1. Its output is inactive while the count is below duty and active otherwise. A duty of zero gives a fully active output, and a duty at or above the period gives a fully inactive output. With polarity 0 the active level is high.
- R4: Polarity bit 1 inverts the output. This also applies to the idle level of a stopped channel, which equals the polarity bit.
- R5: Prescaler field n makes one tick every 2^n clock cycles. Values above 10 behave as 10.
- R6: Writing a 1 to bit c of the start register runs channel c. A channel started from the stopped state begins at count 0, with its first tick due 2^n cycles after the start write. Zero bits written to the start or stop register change nothing. Status bit c is 1 while channel c runs.
- R7: A 1 written to bit c of the stop register takes effect at the end of the current period. The status bit and the waveform continue until then. After that the output holds its idle level.
- R8: A write to a staged register is copied into the active duty or period register at the next period end. Until then the active value and the output are unchanged.
- R9: Writes to the active duty and period registers take effect only while the channel is stopped. While it runs they are ignored.
- R10: Each period end sets the channel's bit in the flag word. A read of the flag word returns the flags and clears them. A period end that falls in the same cycle as the clearing read leaves its bit set.
- R11: Reads of unmapped addresses, including misaligned ones, and reads of the start and stop registers return zero. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_re | input | 1 | Read strobe; needed only for the clearing read of the flag word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A register write takes effect at the rising edge that samples it. The output and the status reflect the new state in the cycle that follows. When a channel is started, cycle i after the start edge shows count (i >> n) mod period, so the waveform of every cycle can be predicted. A period end ends with the clock edge after the last tick of that period. Staged values, the stop request and the flag bit all take effect at that edge. The read value of the flag word is combinational, and its clearing happens at the edge that samples the read strobe. The bench drives every input on the falling edge and samples on the next falling edge. Each expected value is computed from this schedule, which places mid-period writes and the clearing read in known cycles. The collision of a period end with a clearing read is aimed at an exact cycle.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  // Global register byte addresses
  localparam int OFS_START = 'h004;
  localparam int OFS_STOP  = 'h008;
  localparam int OFS_STAT  = 'h00C;
  localparam int OFS_FLAG  = 'h01C;

  // Channel banks
  localparam int BANK_BASE   = 'h200;
  localparam int BANK_LSB    = 5;
  localparam int BANK_STRIDE = 1 << BANK_LSB;

  // Mode word field positions
  localparam int POL_BIT = 9;

  typedef enum logic [BANK_LSB-1:0] {
    SUB_MODE = 5'h00,
    SUB_DTY  = 5'h04,
    SUB_DSTG = 5'h08,
    SUB_PRD  = 5'h0C,
    SUB_PSTG = 5'h10
  } sub_e;

endpackage

// File: rtl/pwmc_div.sv
// Power-of-two tick generator; restarts from zero when a channel starts.
module pwmc_div #(
  parameter int SEL_W   = 4,
  parameter int MAX_EXP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [CW-1:0]    div_q, div_d;
  logic [CW-1:0]    lim;
  logic [SEL_W-1:0] exp_c;

  always_comb begin
    exp_c = (sel > SEL_W'(MAX_EXP)) ? SEL_W'(MAX_EXP) : sel;
    lim   = ~({CW{1'b1}} << exp_c);
    tick  = active && (div_q == lim);
    div_d = div_q;
    if (restart)     div_d = '0;
    else if (active) div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwmc_isr.sv
// Sticky per-channel period-end flags, cleared by a read; a new event wins.
module pwmc_isr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flg_q, flg_d;

  always_comb flg_d = (clr ? '0 : flg_q) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/pwmc_chan.sv
// One channel: mode, active and staged values, run control, counter, output.
module pwmc_chan #(
  parameter int DW      = 16,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mode,
  input  logic             wr_dty,
  input  logic             wr_dstg,
  input  logic             wr_prd,
  input  logic             wr_pstg,
  input  logic [DW-1:0]    wval,
  input  logic [PRE_W-1:0] pre_in,
  input  logic             pol_in,
  input  logic             en_req,
  input  logic             dis_req,
  output logic             run,
  output logic             prd_end,
  output logic             out,
  output logic [DW-1:0]    cnt,
  output logic [DW-1:0]    dty,
  output logic [DW-1:0]    prd,
  output logic [DW-1:0]    dstg,
  output logic [DW-1:0]    pstg,
  output logic [PRE_W-1:0] pre,
  output logic             pol
);
  logic             run_q, run_d, stop_q, stop_d;
  logic [DW-1:0]    cnt_q, cnt_d, dty_q, dty_d, prd_q, prd_d;
  logic [DW-1:0]    dstg_q, dstg_d, pstg_q, pstg_d;
  logic             dpend_q, dpend_d, ppend_q, ppend_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pol_q, pol_d;
  logic             tick, last, end_c;

  pwmc_div #(.SEL_W(PRE_W), .MAX_EXP(PRE_MAX)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (en_req && !run_q),
    .active  (run_q),
    .sel     (pre_q),
    .tick    (tick)
  );

  always_comb begin
    last  = ({1'b0, cnt_q} + (DW+1)'(1)) >= {1'b0, prd_q};
    end_c = run_q && tick && last;

    run_d = run_q;   stop_d = stop_q;  cnt_d = cnt_q;
    dty_d = dty_q;   prd_d  = prd_q;
    dstg_d = dstg_q; pstg_d = pstg_q;
    dpend_d = dpend_q; ppend_d = ppend_q;
    pre_d = pre_q;   pol_d  = pol_q;

    if (wr_mode) begin
      pre_d = pre_in;
      pol_d = pol_in;
    end
    if (run_q && tick) cnt_d = last ? '0 : cnt_q + 1'b1;
    if (end_c) begin
      if (dpend_q) begin dty_d = dstg_q; dpend_d = 1'b0; end
      if (ppend_q) begin prd_d = pstg_q; ppend_d = 1'b0; end
      if (stop_q)  begin run_d = 1'b0;   stop_d  = 1'b0; end
    end
    if (wr_dstg) begin dstg_d = wval; dpend_d = 1'b1; end
    if (wr_pstg) begin pstg_d = wval; ppend_d = 1'b1; end
    if (wr_dty && !run_q) dty_d = wval;
    if (wr_prd && !run_q) prd_d = wval;
    if (dis_req && run_q) stop_d = 1'b1;
    if (en_req) begin
      run_d  = 1'b1;
      stop_d = 1'b0;
      if (!run_q) cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;  stop_q <= 1'b0;  cnt_q <= '0;
      dty_q <= '0;    prd_q  <= '0;
      dstg_q <= '0;   pstg_q <= '0;
      dpend_q <= 1'b0; ppend_q <= 1'b0;
      pre_q <= '0;    pol_q  <= 1'b0;
    end else begin
      run_q <= run_d;  stop_q <= stop_d;  cnt_q <= cnt_d;
      dty_q <= dty_d;  prd_q  <= prd_d;
      dstg_q <= dstg_d; pstg_q <= pstg_d;
      dpend_q <= dpend_d; ppend_q <= ppend_d;
      pre_q <= pre_d;  pol_q  <= pol_d;
    end
  end

  assign out     = run_q ? ((cnt_q >= dty_q) ^ pol_q) : pol_q;
  assign run     = run_q;
  assign prd_end = end_c;
  assign cnt     = cnt_q;
  assign dty     = dty_q;
  assign prd     = prd_q;
  assign dstg    = dstg_q;
  assign pstg    = pstg_q;
  assign pre     = pre_q;
  assign pol     = pol_q;
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NCH-1:0]         run_v, end_v, pol_v, isr_v, en_v, dis_v;
  logic [NCH-1:0][DW-1:0] cnt_v, dty_v, prd_v;
  logic [NCH-1:0][31:0]   rd_ch;
  logic                   isr_clr;
  logic                   unused_wbits;

  assign unused_wbits = ^(bus_wdata >> DW);
  assign en_v    = (bus_we && bus_addr == AW'(OFS_START)) ? bus_wdata[NCH-1:0] : '0;
  assign dis_v   = (bus_we && bus_addr == AW'(OFS_STOP))  ? bus_wdata[NCH-1:0] : '0;
  assign isr_clr = bus_re && (bus_addr == AW'(OFS_FLAG));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] BASE_I = AW'(BANK_BASE + i * BANK_STRIDE);
    logic                bank_hit;
    logic [BANK_LSB-1:0] sub;
    logic [DW-1:0]       dstg, pstg;
    logic [PRE_W-1:0]    pre;

    assign bank_hit = bus_addr[AW-1:BANK_LSB] == BASE_I[AW-1:BANK_LSB];
    assign sub      = bus_addr[BANK_LSB-1:0];

    pwmc_chan #(.DW(DW), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_chan (
      .clk     (clk),
      .rst_n   (rst_ni),
      .wr_mode (bus_we && bank_hit && sub == SUB_MODE),
      .wr_dty  (bus_we && bank_hit && sub == SUB_DTY),
      .wr_dstg (bus_we && bank_hit && sub == SUB_DSTG),
      .wr_prd  (bus_we && bank_hit && sub == SUB_PRD),
      .wr_pstg (bus_we && bank_hit && sub == SUB_PSTG),
      .wval    (bus_wdata[DW-1:0]),
      .pre_in  (bus_wdata[PRE_W-1:0]),
      .pol_in  (bus_wdata[POL_BIT]),
      .en_req  (en_v[i]),
      .dis_req (dis_v[i]),
      .run     (run_v[i]),
      .prd_end (end_v[i]),
      .out     (pwm_out[i]),
      .cnt     (cnt_v[i]),
      .dty     (dty_v[i]),
      .prd     (prd_v[i]),
      .dstg    (dstg),
      .pstg    (pstg),
      .pre     (pre),
      .pol     (pol_v[i])
    );

    always_comb begin
      rd_ch[i] = '0;
      if (bank_hit) begin
        case (sub)
          SUB_MODE: begin
            rd_ch[i][PRE_W-1:0] = pre;
            rd_ch[i][POL_BIT]   = pol_v[i];
          end
          SUB_DTY:  rd_ch[i][DW-1:0] = dty_v[i];
          SUB_DSTG: rd_ch[i][DW-1:0] = dstg;
          SUB_PRD:  rd_ch[i][DW-1:0] = prd_v[i];
          SUB_PSTG: rd_ch[i][DW-1:0] = pstg;
          default:  rd_ch[i] = '0;
        endcase
      end
    end
  end

  pwmc_isr #(.N(NCH)) u_isr (
    .clk   (clk),
    .rst_n (rst_ni),
    .set   (end_v),
    .clr   (isr_clr),
    .flags (isr_v)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_STAT)) bus_rdata[NCH-1:0] = run_v;
    if (bus_addr == AW'(OFS_FLAG)) bus_rdata[NCH-1:0] = isr_v;
    for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | rd_ch[i];
  end
endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         pend,
  input logic [NCH-1:0]         isr,
  input logic                   isr_clr,
  input logic [NCH-1:0][DW-1:0] cnt,
  input logic [NCH-1:0][DW-1:0] prd,
  input logic [NCH-1:0][DW-1:0] dty,
  input logic [NCH-1:0]         pol,
  input logic [NCH-1:0]         pwm_out
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R10: a period end always leaves its flag set
    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] |=> isr[i]);
    // R10: a clearing read with no new event empties the flag
    p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_clr && !pend[i]) |=> !isr[i]);
    // R7: a running channel stops only at a period end
    p_stop_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && !pend[i]) |=> run[i]);
    // R3: the count stays inside the period
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && prd[i] != '0) |-> (cnt[i] < prd[i]));
    // R8 and R9: active duty and period move only at a period end while running
    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && !pend[i]) |=> ($stable(dty[i]) && $stable(prd[i])));
    // R4: a stopped channel shows its idle level
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> (pwm_out[i] == pol[i]));
  end
endmodule

bind pwmc_top pwmc_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_ni),
  .run     (run_v),
  .pend    (end_v),
  .isr     (isr_v),
  .isr_clr (isr_clr),
  .cnt     (cnt_v),
  .prd     (prd_v),
  .dty     (dty_v),
  .pol     (pol_v),
  .pwm_out (pwm_out)
);

// File: tb/pwmc_top_tb_top.sv
module pwmc_top_tb_top;
  localparam logic [11:0] A_START = 12'h004;
  localparam logic [11:0] A_STOP  = 12'h008;
  localparam logic [11:0] A_STAT  = 12'h00C;
  localparam logic [11:0] A_FLAG  = 12'h01C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we, re;
  logic [31:0] wdata, rdata;
  logic [3:0]  pwm_out;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pwmc_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out)
  );

  function automatic logic [11:0] ra(input int ch, input int sub);
    return 12'(32'h200 + ch * 32'h20 + sub);
  endfunction

  function automatic logic exp_out(input int i, input int pre, input logic pol,
                                   input int prd, input int dty);
    int e = (pre > 10) ? 10 : pre;
    int c = (i >> e) % prd;
    return pol ^ (c >= dty);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = '0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    #2 d = rdata;
    @(posedge clk); #1;
    re = 1'b0; addr = '0;
  endtask

  // R3 / R4 / R5 / R6: full waveform from the start edge
  task automatic t_wave(input string tag, input int ch, input int pre, input logic pol,
                        input int prd, input int dty, input int n);
    int mism = 0;
    do_reset();
    bus_wr(ra(ch, 'h00), (32'(pol) << 9) | 32'(pre));
    bus_wr(ra(ch, 'h0C), 32'(prd));
    bus_wr(ra(ch, 'h04), 32'(dty));
    bus_wr(A_START, 32'(1) << ch);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] !== exp_out(i, pre, pol, prd, dty)) begin
        if (mism == 0) $display("  %s first mismatch at cycle %0d", tag, i);
        mism++;
      end
    end
    chk(tag, 32'(mism), 32'd0);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    chk("R1 outputs low", {28'd0, pwm_out}, 32'd0);
    bus_rd(A_STAT, d);        chk("R1 status", d, 32'd0);
    bus_rd(A_FLAG, d);        chk("R1 flags", d, 32'd0);
    bus_rd(ra(0, 'h00), d);   chk("R1 mode", d, 32'd0);
    bus_rd(ra(3, 'h0C), d);   chk("R1 period", d, 32'd0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    do_reset();
    bus_wr(ra(1, 'h0C), 32'hABCD_1234);
    bus_rd(ra(1, 'h0C), d);   chk("R2 period 16 bits", d, 32'h0000_1234);
    bus_wr(ra(3, 'h00), 32'hFFFF_FFFF);
    bus_rd(ra(3, 'h00), d);   chk("R2 mode fields", d, 32'h0000_020F);
    bus_wr(ra(0, 'h08), 32'h5555_AAAA);
    bus_rd(ra(0, 'h08), d);   chk("R2 staged duty", d, 32'h0000_AAAA);
    bus_wr(ra(2, 'h10), 32'h0001_0042);
    bus_rd(ra(2, 'h10), d);   chk("R2 staged period", d, 32'h0000_0042);
    bus_wr(ra(2, 'h04), 32'h0000_0033);
    bus_rd(ra(2, 'h04), d);   chk("R9 duty write while stopped", d, 32'h0000_0033);
  endtask

  task automatic t_idle_pol();
    do_reset();
    bus_wr(ra(1, 'h00), 32'h0000_0200);
    @(negedge clk);
    chk("R4 idle level follows polarity", {28'd0, pwm_out}, 32'h0000_0002);
  endtask

  // R8 / R9: staged values land at the period end, active writes ignored while running
  task automatic t_update();
    int mism = 0;
    logic [31:0] d;
    logic e;
    do_reset();
    bus_wr(ra(1, 'h0C), 32'd8);
    bus_wr(ra(1, 'h04), 32'd3);
    bus_wr(A_START, 32'h2);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      e = (i < 8) ? exp_out(i, 0, 1'b0, 8, 3) : exp_out(i - 8, 0, 1'b0, 12, 6);
      if (pwm_out[1] !== e) begin
        if (mism == 0) $display("  update first mismatch at cycle %0d", i);
        mism++;
      end
      case (i)
        1: begin addr = ra(1, 'h04); we = 1'b1; wdata = 32'd7;  end
        2: begin addr = ra(1, 'h08); we = 1'b1; wdata = 32'd6;  end
        5: begin addr = ra(1, 'h10); we = 1'b1; wdata = 32'd12; end
        default: begin addr = '0; we = 1'b0; end
      endcase
    end
    chk("R8 R9 waveform across update", 32'(mism), 32'd0);
    bus_rd(ra(1, 'h04), d);  chk("R8 duty applied", d, 32'd6);
    bus_rd(ra(1, 'h0C), d);  chk("R8 period applied", d, 32'd12);
  endtask

  // R7 / R6: stop at period end, then restart from count zero
  task automatic t_disable();
    int ms = 0, mo = 0, mr = 0;
    do_reset();
    bus_wr(ra(2, 'h00), 32'h0000_0200);
    bus_wr(ra(2, 'h0C), 32'd8);
    bus_wr(ra(2, 'h04), 32'd3);
    bus_wr(A_START, 32'h4);
    addr = A_STAT;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i != 3 && rdata[2] !== (i < 8)) ms++;
      if (pwm_out[2] !== ((i < 8) ? exp_out(i, 0, 1'b1, 8, 3) : 1'b1)) mo++;
      if (i == 2) begin addr = A_STOP; we = 1'b1; wdata = 32'h4; end
      else if (i == 3) begin addr = A_STAT; we = 1'b0; end
    end
    addr = '0;
    chk("R7 status held to period end", 32'(ms), 32'd0);
    chk("R7 waveform then idle", 32'(mo), 32'd0);
    bus_wr(A_START, 32'h4);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pwm_out[2] !== exp_out(i, 0, 1'b1, 8, 3)) mr++;
    end
    chk("R6 restart from count zero", 32'(mr), 32'd0);
  endtask

  task automatic t_zero_bits();
    logic [31:0] d;
    do_reset();
    bus_wr(ra(0, 'h0C), 32'd4);
    bus_wr(ra(0, 'h04), 32'd1);
    bus_wr(A_START, 32'h1);
    bus_wr(A_STOP, 32'h0);
    bus_wr(A_STOP, 32'hE);
    bus_wr(A_START, 32'h0);
    repeat (10) @(posedge clk);
    bus_rd(A_STAT, d);
    chk("R6 zero bits and other-channel stop ignored", d, 32'h1);
  endtask

  // R10: flag set, read-clear, and set winning over a simultaneous clear
  task automatic t_flags();
    do_reset();
    bus_wr(ra(0, 'h0C), 32'd16);
    bus_wr(ra(0, 'h04), 32'd4);
    bus_wr(A_START, 32'h1);
    for (int i = 0; i < 34; i++) begin
      @(negedge clk);
      if (i == 10) chk("R10 no flag before period end", rdata, 32'h0);
      if (i == 17) chk("R10 flag survives clearing read", rdata, 32'h1);
      if (i == 19) chk("R10 read clears flag", rdata, 32'h0);
      if (i == 33) chk("R10 next period end flagged", rdata, 32'h1);
      case (i)
        9:  begin addr = A_FLAG; re = 1'b0; end
        15: re = 1'b1;
        16: re = 1'b0;
        17: re = 1'b1;
        18: re = 1'b0;
        default: ;
      endcase
    end
    addr = '0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset();
    bus_wr(12'h100, 32'hFFFF_FFFF);
    bus_wr(12'h280, 32'hFFFF_FFFF);
    bus_wr(12'h206, 32'hFFFF_FFFF);
    bus_wr(12'h214, 32'hFFFF_FFFF);
    bus_rd(12'h100, d);       chk("R11 unmapped read", d, 32'd0);
    bus_rd(12'h214, d);       chk("R11 unmapped bank slot", d, 32'd0);
    bus_rd(A_START, d);       chk("R11 start reads zero", d, 32'd0);
    bus_rd(ra(0, 'h00), d);   chk("R11 misaligned write ignored", d, 32'd0);
    bus_rd(ra(0, 'h10), d);   chk("R11 bank untouched", d, 32'd0);
    bus_rd(A_STAT, d);        chk("R11 nothing started", d, 32'd0);
    chk("R11 outputs still low", {28'd0, pwm_out}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_readback();
    t_wave("R3 duty 3 of 8", 0, 0, 1'b0, 8, 3, 24);
    t_wave("R3 duty zero fully active", 0, 0, 1'b0, 5, 0, 12);
    t_wave("R3 duty above period fully inactive", 3, 0, 1'b0, 6, 9, 14);
    t_wave("R4 inverted polarity", 1, 0, 1'b1, 8, 3, 24);
    t_wave("R5 prescaler 2^2", 3, 2, 1'b0, 4, 2, 40);
    t_wave("R5 prescaler field 15 acts as 10", 0, 15, 1'b0, 2, 1, 2100);
    t_idle_pol();
    t_update();
    t_disable();
    t_zero_bits();
    t_flags();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule